// File: doc/BRIEF.md
# Message-Signalled Interrupt Indicator Setter

This block receives message-signalled interrupt writes from one device function. Each accepted message becomes two bit updates in a byte-addressed memory. The first update sets a per-vector indicator bit. The second sets a shared summary bit. Each update is a locked read-modify-write of a single byte that ORs one bit into the byte, so no other writer can slip in between the read and the write. A CPU adapter interrupt, tagged with the configured interrupt subclass, is raised only when the summary byte held zero before the update.

Bit numbering inside a byte runs from the most significant end, so bit number 0 is mask 0x80. The bit number of an update is a configured offset plus the vector carried in the message. Software places the indicator area and the summary area through base-address and bit-offset inputs. While a message is being processed, the message port is held not-ready. A read of the notification window always returns all ones.

Top module: `msi_indicator_notifier`

## Requirements
- R1: The vector is the low VEC_W bits (default 11) of the message word. Byte lane 0 (bits 7:0) is the least significant byte, so the word is little-endian. Bits above the vector field have no effect.
- R2: While `fn_enabled` is low, a message is accepted and then dropped. It makes no memory access, raises no interrupt and reports no error.
- R3: Let the indicator bit number be n = `cfg_ind_off` + vector. The indicator update targets byte `cfg_ind_base` + n/8 with mask 0x80 >> (n mod 8).
- R4: The summary update targets byte `cfg_sum_base` + `cfg_sum_off`/8 with mask 0x80 >> (`cfg_sum_off` mod 8).
- R5: Each update reads the byte and then writes back the old value ORed with the mask, so all other bits are kept. `mem_lock` is high on every cycle a request is outstanding, from the read through the write.
- R6: After both updates, `irq_pulse` is high for exactly one cycle with `irq_isc` = `cfg_isc`, but only if the summary byte read as 0x00. Otherwise no interrupt is raised.
- R7: A `win_rd_en` pulse produces `win_rd_valid` on the next cycle with `win_rd_data` = 0xFFFFFFFF.
- R8: An access answered with `mem_err` ends the message at once. `err_event` pulses for one cycle, the failing byte is not written, no later update is made and no interrupt is raised.
- R9: `msg_ready` is low from the acceptance of an enabled message until its last access completes. It is never high while a memory request is outstanding.
- R10: The indicator byte is written before the summary byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message write present |
| msg_ready | output | 1 | Message accepted on this cycle when valid |
| msg_data | input | 32 | Message data word, little-endian |
| fn_enabled | input | 1 | Function is in the enabled state |
| win_rd_en | input | 1 | Read of the notification window |
| win_rd_valid | output | 1 | Window read data valid |
| win_rd_data | output | 32 | Window read data |
| cfg_ind_base | input | ADDR_W | Indicator area byte address |
| cfg_ind_off | input | OFF_W | Indicator bit offset |
| cfg_sum_base | input | ADDR_W | Summary area byte address |
| cfg_sum_off | input | OFF_W | Summary bit offset |
| cfg_isc | input | ISC_W | Interrupt subclass |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Lock held across the read-modify-write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with ack |
| mem_rdata | input | 8 | Read data, valid with ack |
| irq_pulse | output | 1 | Adapter interrupt request |
| irq_isc | output | ISC_W | Subclass of the interrupt |
| err_event | output | 1 | Adapter indicator error event |

## Verification
On every cycle, the embedded assertions check four things: the lock covers every outstanding request, a write is never issued without a lock already held, the message port stays closed while memory is busy, and an interrupt or error is always a single-cycle pulse that never coincides with the other. The assertions also tie each window read response to its request. The directed scenarios check what only memory contents and event counts can show. These are the bit placement for several offsets and vectors, the preservation of neighbouring bits, interrupt suppression when the summary byte was already non-zero, the write order, dropping of messages while the function is disabled, and the abort after a failed access.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_IND_RD = 3'd1,
        ST_IND_WR = 3'd2,
        ST_SUM_RD = 3'd3,
        ST_SUM_WR = 3'd4
    } rmw_state_e;

    localparam logic [31:0] WINDOW_READ_VALUE = 32'hFFFF_FFFF;

    // MSB-first mask: bit number 0 selects 0x80
    function automatic logic [7:0] msb_first_mask(input logic [2:0] bit_in_byte);
        return 8'h80 >> bit_in_byte;
    endfunction

endpackage

// File: rtl/msi_bit_locator.sv
module msi_bit_locator #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 16,
    parameter int VEC_W  = 11
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        bit_mask
);
    import msi_ind_pkg::*;

    localparam int BN_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

    logic [BN_W-1:0] bitnum;

    always_comb begin
        bitnum    = BN_W'(offset) + BN_W'(vec);
        byte_addr = base + ADDR_W'(bitnum >> 3);
        bit_mask  = msb_first_mask(bitnum[2:0]);
    end
endmodule

// File: rtl/msi_rmw_seq.sv
module msi_rmw_seq #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ind_addr,
    input  logic [7:0]        ind_mask,
    input  logic [ADDR_W-1:0] sum_addr,
    input  logic [7:0]        sum_mask,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              done_irq,
    output logic              done_err
);
    import msi_ind_pkg::*;

    rmw_state_e        state_q;
    logic [ADDR_W-1:0] ind_addr_q, sum_addr_q;
    logic [7:0]        ind_mask_q, sum_mask_q;
    logic [7:0]        old_q;
    logic              sum_was_zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            ind_addr_q     <= '0;
            sum_addr_q     <= '0;
            ind_mask_q     <= '0;
            sum_mask_q     <= '0;
            old_q          <= '0;
            sum_was_zero_q <= 1'b0;
            done_irq       <= 1'b0;
            done_err       <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            done_err <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    ind_addr_q <= ind_addr;
                    ind_mask_q <= ind_mask;
                    sum_addr_q <= sum_addr;
                    sum_mask_q <= sum_mask;
                    state_q    <= ST_IND_RD;
                end
                ST_IND_RD: if (mem_ack) begin
                    if (mem_err) begin
                        done_err <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        old_q   <= mem_rdata;
                        state_q <= ST_IND_WR;
                    end
                end
                ST_IND_WR: if (mem_ack) begin
                    if (mem_err) begin
                        done_err <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q <= ST_SUM_RD;
                    end
                end
                ST_SUM_RD: if (mem_ack) begin
                    if (mem_err) begin
                        done_err <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        old_q          <= mem_rdata;
                        sum_was_zero_q <= (mem_rdata == 8'h00);
                        state_q        <= ST_SUM_WR;
                    end
                end
                ST_SUM_WR: if (mem_ack) begin
                    if (mem_err) done_err <= 1'b1;
                    else         done_irq <= sum_was_zero_q;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        mem_req   = !idle;
        mem_lock  = !idle;
        mem_we    = (state_q == ST_IND_WR) || (state_q == ST_SUM_WR);
        mem_addr  = ((state_q == ST_IND_RD) || (state_q == ST_IND_WR)) ? ind_addr_q : sum_addr_q;
        mem_wdata = old_q | (((state_q == ST_IND_WR)) ? ind_mask_q : sum_mask_q);
    end

    // R5
    rmw_write_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_lock));
    // R8
    err_irq_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        done_err |-> !done_irq);
endmodule

// File: rtl/msi_indicator_notifier.sv
module msi_indicator_notifier #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 16,
    parameter int VEC_W  = 11,
    parameter int ISC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [31:0]       msg_data,
    input  logic              fn_enabled,
    input  logic              win_rd_en,
    output logic              win_rd_valid,
    output logic [31:0]       win_rd_data,
    input  logic [ADDR_W-1:0] cfg_ind_base,
    input  logic [OFF_W-1:0]  cfg_ind_off,
    input  logic [ADDR_W-1:0] cfg_sum_base,
    input  logic [OFF_W-1:0]  cfg_sum_off,
    input  logic [ISC_W-1:0]  cfg_isc,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    output logic              irq_pulse,
    output logic [ISC_W-1:0]  irq_isc,
    output logic              err_event
);
    import msi_ind_pkg::*;

    logic [VEC_W-1:0]  vec;
    logic [ADDR_W-1:0] ind_addr, sum_addr;
    logic [7:0]        ind_mask, sum_mask;
    logic              seq_idle, start, done_irq, done_err;

    // R1: little-endian word, vector sits in the least significant bits
    assign vec   = msg_data[VEC_W-1:0];
    assign msg_ready = seq_idle;
    // R2: disabled function -> accepted and dropped
    assign start = msg_valid && seq_idle && fn_enabled;

    msi_bit_locator #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) ind_loc_i (
        .base(cfg_ind_base), .offset(cfg_ind_off), .vec(vec),
        .byte_addr(ind_addr), .bit_mask(ind_mask));

    msi_bit_locator #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) sum_loc_i (
        .base(cfg_sum_base), .offset(cfg_sum_off), .vec('0),
        .byte_addr(sum_addr), .bit_mask(sum_mask));

    msi_rmw_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst(rst), .start(start),
        .ind_addr(ind_addr), .ind_mask(ind_mask),
        .sum_addr(sum_addr), .sum_mask(sum_mask),
        .idle(seq_idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .done_irq(done_irq), .done_err(done_err));

    logic rd_valid_q;
    always_ff @(posedge clk) begin
        if (rst) rd_valid_q <= 1'b0;
        else     rd_valid_q <= win_rd_en;
    end

    always_comb begin
        win_rd_valid = rd_valid_q;
        win_rd_data  = rd_valid_q ? WINDOW_READ_VALUE : 32'h0;
        irq_pulse    = done_irq;
        irq_isc      = done_irq ? cfg_isc : '0;
        err_event    = done_err;
    end

    // R5
    lock_covers_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);
    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !msg_ready);
    // R6
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);
    // R8
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        err_event |=> !err_event);
    // R7
    win_rd_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        win_rd_en |=> win_rd_valid);
endmodule

// File: tb/msi_indicator_notifier_tb.sv
module msi_indicator_notifier_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        msg_valid = 0, msg_ready, fn_enabled = 1, win_rd_en = 0, win_rd_valid;
    logic [31:0] msg_data = 0, win_rd_data;
    logic [15:0] cfg_ind_base = 16'h0010, cfg_sum_base = 16'h0030;
    logic [15:0] cfg_ind_off = 16'd3, cfg_sum_off = 16'd5;
    logic [2:0]  cfg_isc = 3'd5, irq_isc;
    logic        mem_req, mem_we, mem_lock, mem_ack = 0, mem_err = 0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 0;
    logic        irq_pulse, err_event;

    msi_indicator_notifier dut_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_data(msg_data), .fn_enabled(fn_enabled), .win_rd_en(win_rd_en),
        .win_rd_valid(win_rd_valid), .win_rd_data(win_rd_data),
        .cfg_ind_base(cfg_ind_base), .cfg_ind_off(cfg_ind_off),
        .cfg_sum_base(cfg_sum_base), .cfg_sum_off(cfg_sum_off), .cfg_isc(cfg_isc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .irq_pulse(irq_pulse), .irq_isc(irq_isc),
        .err_event(err_event));

    int checks = 0, errors = 0;
    logic [7:0] mem [64];
    int   irq_cnt = 0, err_cnt = 0, wr_cnt = 0, acc_cnt = 0, viol_cnt = 0;
    logic [2:0] last_isc = 0;
    logic [15:0] wr_log [4];
    logic        err_on = 0;
    logic [15:0] err_addr = 0;

    // Memory model: one-cycle ack, write applied on the ack edge
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 0; mem_err <= 0;
        end else begin
            if (mem_req && mem_ack && mem_we && !mem_err) begin
                mem[mem_addr[5:0]] <= mem_wdata;
                if (wr_cnt < 4) wr_log[wr_cnt] <= mem_addr;
                wr_cnt <= wr_cnt + 1;
            end
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1;
                mem_err   <= err_on && (mem_addr == err_addr);
                mem_rdata <= mem[mem_addr[5:0]];
                acc_cnt   <= acc_cnt + 1;
            end else begin
                mem_ack <= 0; mem_err <= 0;
            end
            if (irq_pulse) begin irq_cnt <= irq_cnt + 1; last_isc <= irq_isc; end
            if (err_event) err_cnt <= err_cnt + 1;
            if ((mem_req && !mem_lock) || (mem_req && msg_ready)) viol_cnt <= viol_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1; msg_data = d;
        do @(negedge clk); while (!msg_ready && 0);
        msg_valid = 0;
        repeat (2) @(negedge clk);
        while (!msg_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset ready", msg_ready, 1);
        chk("R5 reset no req", mem_req, 0);
        chk("R6 reset no irq", irq_pulse, 0);
    endtask

    task automatic t_first();
        int i0 = irq_cnt, w0 = wr_cnt;
        // vec=2 (bits above 11 set), n=5 -> 0x10/0x04; summary n=5 -> 0x30/0x04
        send(32'hFFFF_F802);
        chk("R1 R3 indicator byte", mem[6'h10], 8'h04);
        chk("R4 summary byte", mem[6'h30], 8'h04);
        chk("R6 irq on zero summary", irq_cnt - i0, 1);
        chk("R6 irq subclass", last_isc, 3'd5);
        chk("R10 first write indicator", wr_log[w0], 16'h0010);
        chk("R10 second write summary", wr_log[w0+1], 16'h0030);
    endtask

    task automatic t_second();
        int i0 = irq_cnt;
        // vec=13, n=16 -> 0x12/0x80; summary already set
        send(32'h0000_000D);
        chk("R3 indicator n=16", mem[6'h12], 8'h80);
        chk("R5 neighbour kept", mem[6'h10], 8'h04);
        chk("R6 no irq on set summary", irq_cnt - i0, 0);
    endtask

    task automatic t_preserve();
        int i0;
        mem[6'h11] = 8'h21; mem[6'h30] = 8'h01;
        i0 = irq_cnt;
        // vec=6, n=9 -> 0x11/0x40
        send(32'h0000_0006);
        chk("R5 OR keeps bits", mem[6'h11], 8'h61);
        chk("R4 summary OR", mem[6'h30], 8'h05);
        chk("R6 nonzero other bit no irq", irq_cnt - i0, 0);
        mem[6'h30] = 8'h00;
        cfg_sum_off = 16'd10; // summary 0x31 mask 0x20
        i0 = irq_cnt;
        send(32'h0000_0006);
        chk("R4 summary offset 10", mem[6'h31], 8'h20);
        chk("R6 irq again", irq_cnt - i0, 1);
        cfg_sum_off = 16'd5;
    endtask

    task automatic t_disabled();
        int a0 = acc_cnt, i0 = irq_cnt, e0 = err_cnt;
        fn_enabled = 0;
        send(32'h0000_0001);
        chk("R2 no memory access", acc_cnt - a0, 0);
        chk("R2 no irq", irq_cnt - i0, 0);
        chk("R2 no error", err_cnt - e0, 0);
        chk("R2 ready", msg_ready, 1);
        fn_enabled = 1;
    endtask

    task automatic t_window();
        @(negedge clk); win_rd_en = 1;
        @(negedge clk); win_rd_en = 0;
        chk("R7 window valid", win_rd_valid, 1);
        chk("R7 window data", win_rd_data, 32'hFFFF_FFFF);
    endtask

    task automatic t_error();
        int i0, e0;
        mem[6'h30] = 8'h00; mem[6'h13] = 8'h00;
        err_on = 1; err_addr = 16'h0013; // vec=21, n=24 -> 0x13
        i0 = irq_cnt; e0 = err_cnt;
        send(32'h0000_0015);
        chk("R8 error event", err_cnt - e0, 1);
        chk("R8 no irq", irq_cnt - i0, 0);
        chk("R8 failing byte unwritten", mem[6'h13], 8'h00);
        chk("R8 summary untouched", mem[6'h30], 8'h00);
        err_on = 0;
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_first();
        t_second();
        t_preserve();
        t_disabled();
        t_window();
        t_error();
        chk("R5 R9 lock and ready monitor", viol_cnt, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule